// File: doc/BRIEF.md
# Constant-Geometry NTT Stage Sequencer

This block drives the memory side of an n-point radix-2 number-theoretic transform that uses the constant-geometry dataflow, where n is a power of two. Coefficients sit in two banks of n/2 words each. A second copy of both banks forms a ping-pong pair. In every cycle of a run the sequencer issues one butterfly: a read address shared by both banks, the bank set to read, and a twiddle-ROM index. After the fixed latency of an external butterfly it issues the matching write strobes, addresses, bank and set selects for both butterfly results. The arithmetic and the ROM contents are outside this block.

A run is started by a one-cycle request while the block is idle. It then streams log2(n) stages of n/2 butterflies each, with no gap inside a stage or between stages. Stage 0 reads the input, which is stored in natural halves (low half in bank A, high half in bank B), in bit-reversed address order. Every later stage reads an even/odd layout in ascending order. Each stage writes into the bank set it is not reading. The two results of one butterfly land in the same bank, so the sequencer writes the upper result one cycle after the lower one. This keeps the two writes of any cycle in opposite banks. When the last write of the last stage has been made, a one-cycle done pulse follows.

Parameters: `LOG_N` (log2 of the transform length, at least 3) and `LAT` (butterfly latency in cycles, at least 1).

Top module: `ntt_stage_seq`

## Requirements
- R1: While reset is held and after its release, busy, donePulse, rdEn, wrTopEn and wrBotEn are all 0.
- R2: A startReq sampled high while idle makes rdEn high for exactly LOG_N·n/2 consecutive cycles, starting in the next cycle. busy stays high from that cycle through the done pulse. No read or write enable is high while busy is low.
- R3: In stage 0, butterfly j reads rdAddr = bit-reverse of j over LOG_N−1 bits. In every later stage, butterfly j reads rdAddr = j, so addresses ascend by one within the stage.
- R4: twAddr carries the mode in its most significant bit (0 forward, 1 inverse), taken from invMode at the accepted start. Its low LOG_N−1 bits are the exponent floor(j / 2^(LOG_N−1−s))·2^(LOG_N−1−s) for stage s, so the exponent is 0 throughout stage 0.
- R5: Stage s reads bank set rdSet = s mod 2. Both writes produced by stage s use set 1 − (s mod 2).
- R6: Exactly LAT cycles after butterfly j of a stage is read, wrTopEn is 1 with wrTopBank = j mod 2 (0 = bank A, 1 = bank B) and wrTopAddr = floor(j/2).
- R7: Exactly LAT+1 cycles after butterfly j is read, wrBotEn is 1 with wrBotBank = j mod 2 and wrBotAddr = floor(j/2) + n/4.
- R8: Whenever wrTopEn and wrBotEn are both 1, wrTopBank and wrBotBank differ.
- R9: donePulse is high for exactly one cycle, the cycle after the final bottom write of the last stage. busy falls in the cycle after the done pulse.
- R10: A startReq while busy is ignored. Changing invMode while busy does not change twAddr or the number of reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request a run (accepted only when idle) |
| invMode | input | 1 | 1 selects the inverse transform, sampled at start |
| busy | output | 1 | Run in progress, including drain and done cycle |
| donePulse | output | 1 | One-cycle completion pulse |
| rdEn | output | 1 | Read strobe, both banks |
| rdSet | output | 1 | Bank set being read |
| rdAddr | output | LOG_N-1 | Read address shared by bank A and bank B |
| twAddr | output | LOG_N | Twiddle ROM index {mode, exponent} |
| wrTopEn | output | 1 | Write strobe for the lower-index result |
| wrTopSet | output | 1 | Bank set for the lower-index result |
| wrTopBank | output | 1 | Bank (0 A, 1 B) for the lower-index result |
| wrTopAddr | output | LOG_N-1 | Word address for the lower-index result |
| wrBotEn | output | 1 | Write strobe for the upper-index result |
| wrBotSet | output | 1 | Bank set for the upper-index result |
| wrBotBank | output | 1 | Bank (0 A, 1 B) for the upper-index result |
| wrBotAddr | output | LOG_N-1 | Word address for the upper-index result |

## Verification
The properties assume that startReq and invMode are synchronous to clk and that reset is held for at least one edge. They also assume that the butterfly really has the LAT cycles of latency given by the parameter, since every write strobe is timed from the read side only. The stimulus changes inputs only on the falling edge. It begins each run from idle and pokes startReq and a flipped invMode only in the middle of a run, so that the ignore rule is tested without ever producing a second accepted start. Two lengths with different latencies, in both modes, are compared against a model of the stage and index formulas.

// File: rtl/ntt_seq_pkg.sv
package ntt_seq_pkg;

  // sequencer states
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_RUN   = 2'd1,
    SEQ_DRAIN = 2'd2,
    SEQ_FIN   = 2'd3
  } seqState_t;

  // per-cycle strobes from control to the read-side datapath
  typedef struct packed {
    logic issue;       // a butterfly is read this cycle
    logic firstStage;  // stage 0: bit-reversed addressing
    logic setSel;      // bank set read this cycle
  } seqStrobe_t;

endpackage

// File: rtl/ntt_seq_ctrl.sv
module ntt_seq_ctrl
  import ntt_seq_pkg::*;
#(
  parameter int LOG_N = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          startReq,
  input  logic                          invMode,
  input  logic                          lastBotWrite,
  output logic                          busy,
  output logic                          donePulse,
  output seqStrobe_t                    strb,
  output logic                          lastOp,
  output logic [$clog2(LOG_N+1)-1:0]    stageIdx,
  output logic [LOG_N-2:0]              posIdx,
  output logic                          invLat
);

  localparam int AW       = LOG_N - 1;
  localparam int SW       = $clog2(LOG_N + 1);
  localparam int HALF     = 1 << AW;
  localparam logic [AW-1:0] POS_LAST   = AW'(HALF - 1);
  localparam logic [SW-1:0] STAGE_LAST = SW'(LOG_N - 1);

  seqState_t state;

  logic posWrap;
  logic stageWrap;

  assign posWrap   = (posIdx == POS_LAST);
  assign stageWrap = (stageIdx == STAGE_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= SEQ_IDLE;
      stageIdx <= '0;
      posIdx   <= '0;
      invLat   <= 1'b0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (startReq) begin
            state    <= SEQ_RUN;
            stageIdx <= '0;
            posIdx   <= '0;
            invLat   <= invMode;
          end
        end
        SEQ_RUN: begin
          posIdx <= posIdx + 1'b1;
          if (posWrap) begin
            posIdx <= '0;
            if (stageWrap) begin
              state <= SEQ_DRAIN;
            end else begin
              stageIdx <= stageIdx + 1'b1;
            end
          end
        end
        SEQ_DRAIN: begin
          if (lastBotWrite) begin
            state <= SEQ_FIN;
          end
        end
        default: begin
          state <= SEQ_IDLE;
        end
      endcase
    end
  end

  assign busy            = (state != SEQ_IDLE);
  assign donePulse       = (state == SEQ_FIN);
  assign strb.issue      = (state == SEQ_RUN);
  assign strb.firstStage = (stageIdx == '0);
  assign strb.setSel     = stageIdx[0];
  assign lastOp          = strb.issue && posWrap && stageWrap;

endmodule

// File: rtl/ntt_seq_rdgen.sv
module ntt_seq_rdgen
  import ntt_seq_pkg::*;
#(
  parameter int LOG_N = 4
) (
  input  seqStrobe_t                    strb,
  input  logic [$clog2(LOG_N+1)-1:0]    stageIdx,
  input  logic [LOG_N-2:0]              posIdx,
  input  logic                          invLat,
  output logic                          rdEn,
  output logic                          rdSet,
  output logic [LOG_N-2:0]              rdAddr,
  output logic [LOG_N-1:0]              twAddr
);

  localparam int AW = LOG_N - 1;

  logic [AW-1:0] revPos;
  logic [AW-1:0] expo;

  // bit-reversed butterfly index for the stage-0 read order
  for (genvar b = 0; b < AW; b++) begin : g_rev
    assign revPos[b] = posIdx[AW-1-b];
  end

  // exponent keeps bit b of j only when b >= AW - stage
  for (genvar b = 0; b < AW; b++) begin : g_expo
    assign expo[b] = posIdx[b] && ((32'(stageIdx) + b) >= AW);
  end

  assign rdEn   = strb.issue;
  assign rdSet  = strb.issue && strb.setSel;
  assign rdAddr = !strb.issue ? '0 : (strb.firstStage ? revPos : posIdx);
  assign twAddr = strb.issue ? {invLat, expo} : '0;

endmodule

// File: rtl/ntt_seq_wrpipe.sv
module ntt_seq_wrpipe #(
  parameter int LOG_N = 4,
  parameter int LAT   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issue,
  input  logic              setSel,
  input  logic              lastOp,
  input  logic [LOG_N-2:0]  posIdx,
  output logic              wrTopEn,
  output logic              wrTopSet,
  output logic              wrTopBank,
  output logic [LOG_N-2:0]  wrTopAddr,
  output logic              wrBotEn,
  output logic              wrBotSet,
  output logic              wrBotBank,
  output logic [LOG_N-2:0]  wrBotAddr,
  output logic              lastBotWrite
);

  localparam int AW = LOG_N - 1;

  typedef struct packed {
    logic          valid;
    logic          last;
    logic          wset;
    logic [AW-1:0] pos;
  } wrRec_t;

  wrRec_t inRec;
  wrRec_t pipe [LAT];
  wrRec_t topRec;
  wrRec_t botRec;

  assign inRec.valid = issue;
  assign inRec.last  = lastOp;
  assign inRec.wset  = ~setSel;
  assign inRec.pos   = posIdx;

  // delay line matching the butterfly latency
  for (genvar k = 0; k < LAT; k++) begin : g_dly
    if (k == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rstN) pipe[k] <= '0;
        else       pipe[k] <= inRec;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rstN) pipe[k] <= '0;
        else       pipe[k] <= pipe[k-1];
      end
    end
  end

  assign topRec = pipe[LAT-1];

  // upper-index result is held one cycle so it alternates banks with the lower one
  always_ff @(posedge clk) begin
    if (!rstN) botRec <= '0;
    else       botRec <= topRec;
  end

  assign wrTopEn   = topRec.valid;
  assign wrTopSet  = topRec.wset;
  assign wrTopBank = topRec.pos[0];
  assign wrTopAddr = {1'b0, topRec.pos[AW-1:1]};

  assign wrBotEn   = botRec.valid;
  assign wrBotSet  = botRec.wset;
  assign wrBotBank = botRec.pos[0];
  assign wrBotAddr = {1'b1, botRec.pos[AW-1:1]};

  assign lastBotWrite = botRec.valid && botRec.last;

endmodule

// File: rtl/ntt_stage_seq.sv
module ntt_stage_seq
  import ntt_seq_pkg::*;
#(
  parameter int LOG_N = 4,
  parameter int LAT   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              invMode,
  output logic              busy,
  output logic              donePulse,
  output logic              rdEn,
  output logic              rdSet,
  output logic [LOG_N-2:0]  rdAddr,
  output logic [LOG_N-1:0]  twAddr,
  output logic              wrTopEn,
  output logic              wrTopSet,
  output logic              wrTopBank,
  output logic [LOG_N-2:0]  wrTopAddr,
  output logic              wrBotEn,
  output logic              wrBotSet,
  output logic              wrBotBank,
  output logic [LOG_N-2:0]  wrBotAddr
);

  localparam int SW = $clog2(LOG_N + 1);

  seqStrobe_t       strb;
  logic             lastOp;
  logic [SW-1:0]    stageIdx;
  logic [LOG_N-2:0] posIdx;
  logic             invLat;
  logic             lastBotWrite;

  ntt_seq_ctrl #(.LOG_N(LOG_N)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .startReq     (startReq),
    .invMode      (invMode),
    .lastBotWrite (lastBotWrite),
    .busy         (busy),
    .donePulse    (donePulse),
    .strb         (strb),
    .lastOp       (lastOp),
    .stageIdx     (stageIdx),
    .posIdx       (posIdx),
    .invLat       (invLat)
  );

  ntt_seq_rdgen #(.LOG_N(LOG_N)) u_rdgen (
    .strb     (strb),
    .stageIdx (stageIdx),
    .posIdx   (posIdx),
    .invLat   (invLat),
    .rdEn     (rdEn),
    .rdSet    (rdSet),
    .rdAddr   (rdAddr),
    .twAddr   (twAddr)
  );

  ntt_seq_wrpipe #(.LOG_N(LOG_N), .LAT(LAT)) u_wrpipe (
    .clk          (clk),
    .rstN         (rstN),
    .issue        (strb.issue),
    .setSel       (strb.setSel),
    .lastOp       (lastOp),
    .posIdx       (posIdx),
    .wrTopEn      (wrTopEn),
    .wrTopSet     (wrTopSet),
    .wrTopBank    (wrTopBank),
    .wrTopAddr    (wrTopAddr),
    .wrBotEn      (wrBotEn),
    .wrBotSet     (wrBotSet),
    .wrBotBank    (wrBotBank),
    .wrBotAddr    (wrBotAddr),
    .lastBotWrite (lastBotWrite)
  );

endmodule

// File: rtl/ntt_stage_seq_sva.sv
module ntt_stage_seq_sva #(
  parameter int LOG_N = 4,
  parameter int LAT   = 3
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          busy,
  input logic                          donePulse,
  input logic                          rdEn,
  input logic [LOG_N-2:0]              rdAddr,
  input logic [LOG_N-1:0]              twAddr,
  input logic                          wrTopEn,
  input logic                          wrTopBank,
  input logic [LOG_N-2:0]              wrTopAddr,
  input logic                          wrBotEn,
  input logic                          wrBotBank,
  input logic [LOG_N-2:0]              wrBotAddr,
  input logic [$clog2(LOG_N+1)-1:0]    stageIdx
);

  localparam int AW      = LOG_N - 1;
  localparam int QUARTER = 1 << (AW - 1);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!rdEn && !wrTopEn && !wrBotEn)); // R2

  AST_READ_ASCEND: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && $past(rdEn) && stageIdx != '0 && $past(stageIdx) == stageIdx)
      |-> (rdAddr == AW'($past(rdAddr) + 1'b1))); // R3

  AST_STAGE0_TW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && stageIdx == '0) |-> (twAddr[LOG_N-2:0] == '0)); // R4

  AST_BOT_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    wrBotEn |-> ($past(wrTopEn) && wrBotAddr == AW'($past(wrTopAddr) + QUARTER))); // R7

  AST_BANK_SPLIT: assert property (@(posedge clk) disable iff (!rstN)
    (wrTopEn && wrBotEn) |-> (wrTopBank != wrBotBank)); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> (!donePulse && !busy)); // R9

  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> ($past(wrBotEn) && !wrBotEn && !rdEn)); // R9

  AST_MODE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && $past(rdEn)) |-> (twAddr[LOG_N-1] == $past(twAddr[LOG_N-1]))); // R10

endmodule

bind ntt_stage_seq ntt_stage_seq_sva #(.LOG_N(LOG_N), .LAT(LAT)) u_sva (
  .clk       (clk),
  .rstN      (rstN),
  .busy      (busy),
  .donePulse (donePulse),
  .rdEn      (rdEn),
  .rdAddr    (rdAddr),
  .twAddr    (twAddr),
  .wrTopEn   (wrTopEn),
  .wrTopBank (wrTopBank),
  .wrTopAddr (wrTopAddr),
  .wrBotEn   (wrBotEn),
  .wrBotBank (wrBotBank),
  .wrBotAddr (wrBotAddr),
  .stageIdx  (stageIdx)
);

// File: tb/ntt_stage_seq_test.sv
`timescale 1ns/1ps

module ntt_seq_harness #(
  parameter int LOG_N = 4,
  parameter int LAT   = 3
) (
  input  logic clk,
  input  logic rstN,
  output logic finished
);

  localparam int AW  = LOG_N - 1;
  localparam int H   = 1 << AW;
  localparam int Q   = H / 2;
  localparam int TOT = LOG_N * H;

  logic             startReq, invMode;
  logic             busy, donePulse, rdEn, rdSet;
  logic [LOG_N-2:0] rdAddr, wrTopAddr, wrBotAddr;
  logic [LOG_N-1:0] twAddr;
  logic             wrTopEn, wrTopSet, wrTopBank;
  logic             wrBotEn, wrBotSet, wrBotBank;

  ntt_stage_seq #(.LOG_N(LOG_N), .LAT(LAT)) uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .invMode(invMode),
    .busy(busy), .donePulse(donePulse),
    .rdEn(rdEn), .rdSet(rdSet), .rdAddr(rdAddr), .twAddr(twAddr),
    .wrTopEn(wrTopEn), .wrTopSet(wrTopSet), .wrTopBank(wrTopBank), .wrTopAddr(wrTopAddr),
    .wrBotEn(wrBotEn), .wrBotSet(wrBotSet), .wrBotBank(wrBotBank), .wrBotAddr(wrBotAddr)
  );

  typedef struct {
    int cyc;
    int a;
    int b;
    int c;
  } item_t;

  item_t rdQ[$];
  item_t topQ[$];
  item_t botQ[$];

  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  int expDone = -10;
  int extraReads = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL n=%0d %s actual=%0d expected=%0d", H * 2, tag, act, exp);
    end
  endtask

  function automatic int bitRev(input int v);
    int r = 0;
    for (int b = 0; b < AW; b++) r |= ((v >> b) & 1) << (AW - 1 - b);
    return r;
  endfunction

  // driver: push the whole expected schedule, then request the run
  task automatic runOnce(input bit inv, input bit poke);
    int s0;
    @(negedge clk);
    s0 = cyc + 1;
    for (int s = 0; s < LOG_N; s++) begin
      for (int j = 0; j < H; j++) begin
        item_t it;
        int sh;
        int c;
        c  = s0 + s * H + j;
        sh = AW - s;
        it.cyc = c;
        it.a = (s == 0) ? bitRev(j) : j;
        it.b = (int'(inv) << AW) | ((j >> sh) << sh);
        it.c = s & 1;
        rdQ.push_back(it);
        it.cyc = c + LAT;
        it.a = j & 1;
        it.b = j >> 1;
        it.c = (s & 1) ^ 1;
        topQ.push_back(it);
        it.cyc = c + LAT + 1;
        it.b = (j >> 1) + Q;
        botQ.push_back(it);
      end
    end
    expDone  = s0 + TOT + LAT + 1;
    startReq = 1'b1;
    invMode  = inv;
    @(negedge clk);
    startReq = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      startReq = 1'b1;
      invMode  = ~inv;
      @(negedge clk);
      startReq = 1'b0;
    end
    while (cyc <= expDone + 2) @(negedge clk);
    invMode = 1'b0;
    check("R2 all reads issued", rdQ.size(), 0);
    check("R7 all writes issued", botQ.size(), 0);
  endtask

  // monitor: pop expected items and compare against the ports
  always @(negedge clk) begin
    if (rstN) begin
      if (rdQ.size() > 0 && rdQ[0].cyc == cyc) begin
        item_t it;
        it = rdQ.pop_front();
        check("R2 read enable", int'(rdEn), 1);
        check("R3 read address", int'(rdAddr), it.a);
        check("R4 twiddle index", int'(twAddr), it.b);
        check("R5 read set", int'(rdSet), it.c);
      end else if (rdEn) begin
        extraReads++;
        check("R2 unexpected read", 1, 0);
      end
      if (topQ.size() > 0 && topQ[0].cyc == cyc) begin
        item_t it;
        it = topQ.pop_front();
        check("R6 top write enable", int'(wrTopEn), 1);
        check("R6 top bank", int'(wrTopBank), it.a);
        check("R6 top address", int'(wrTopAddr), it.b);
        check("R5 top write set", int'(wrTopSet), it.c);
      end else if (wrTopEn) begin
        check("R6 unexpected top write", 1, 0);
      end
      if (botQ.size() > 0 && botQ[0].cyc == cyc) begin
        item_t it;
        it = botQ.pop_front();
        check("R7 bottom write enable", int'(wrBotEn), 1);
        check("R7 bottom bank", int'(wrBotBank), it.a);
        check("R7 bottom address", int'(wrBotAddr), it.b);
        check("R5 bottom write set", int'(wrBotSet), it.c);
      end else if (wrBotEn) begin
        check("R7 unexpected bottom write", 1, 0);
      end
      if (wrTopEn && wrBotEn) check("R8 banks differ", int'(wrTopBank != wrBotBank), 1);
      if (cyc == expDone) begin
        check("R9 done pulse", int'(donePulse), 1);
        check("R9 busy during done", int'(busy), 1);
      end else if (donePulse) begin
        check("R9 stray done", 1, 0);
      end
      if (cyc == expDone + 1) check("R9 busy released", int'(busy), 0);
      if (cyc > expDone - TOT - LAT - 1 && cyc < expDone) check("R2 busy in run", int'(busy), 1);
    end
  end

  initial begin
    startReq = 1'b0;
    invMode  = 1'b0;
    finished = 1'b0;
    @(negedge clk);
    @(negedge clk);
    if (!rstN) begin
      check("R1 reset busy", int'(busy), 0);
      check("R1 reset done", int'(donePulse), 0);
      check("R1 reset read", int'(rdEn), 0);
      check("R1 reset writes", int'(wrTopEn | wrBotEn), 0);
    end
    while (!rstN) @(negedge clk);
    @(negedge clk);
    check("R1 idle after reset", int'(busy | rdEn | wrTopEn | wrBotEn | donePulse), 0);
    runOnce(1'b0, 1'b1);
    check("R10 start during run ignored", extraReads, 0);
    runOnce(1'b1, 1'b1);
    check("R10 inverse run no extra reads", extraReads, 0);
    runOnce(1'b0, 1'b0);
    finished = 1'b1;
  end

endmodule

module ntt_stage_seq_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fin16, fin32;

  always #2.5 clk = ~clk;

  ntt_seq_harness #(.LOG_N(4), .LAT(3)) h16 (.clk(clk), .rstN(rstN), .finished(fin16));
  ntt_seq_harness #(.LOG_N(5), .LAT(2)) h32 (.clk(clk), .rstN(rstN), .finished(fin32));

  initial begin
    int wait_cycles = 0;
    int wdFail = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    while (!(fin16 && fin32) && wait_cycles < 20000) begin
      @(posedge clk);
      wait_cycles++;
    end
    if (!(fin16 && fin32)) begin
      wdFail = 1;
      $display("FAIL watchdog expired actual=%0d expected=finish", wait_cycles);
    end
    $display("TB_RESULT checks=%0d failures=%0d",
             h16.nChecks + h32.nChecks + wdFail, h16.nFails + h32.nFails + wdFail);
    $finish;
  end

endmodule